// File: doc/BRIEF.md
# Spread-Spectrum Triangular Profile Generator

This block drives the frequency control word of a fractional-N divider so that the synthesized clock sweeps around, or just below, its nominal frequency. The sweep is a linear triangle. It uses the same modulation period whatever nominal word is programmed, and the period is set in reference cycles (about 30 kHz is the usual target). Two shapes are offered. Center spread swings symmetrically above and below nominal. Down spread starts at nominal, sweeps down by the full magnitude and returns, so it never exceeds nominal.

The word advances on an internal update strobe, once every `2**UPD_LOG2` reference cycles. The step per update comes from an exact quotient/remainder accumulator, so each ramp ends on its peak value with no drift from one period to the next. When the shape, magnitude, period or nominal word changes, the new setting is computed in the background and takes effect only at the start of a modulation period. Pulling the enable low forces the plain nominal word. Raising it again restarts the profile at its nominal point.

The output is a one-way stream with a valid strobe and no ready. The profile is paced by time, so the consumer cannot apply back-pressure. It must take each word in the cycle in which `word_valid` is high, and the word holds steady until the next strobe.

Top module: `sscg_profile_gen`

## Requirements
- R1: While reset is held and in the first cycle after release, `word_valid` is 0, `word_out` is 0 and `phase_rising` is 0.
- R2: `word_valid` is high for exactly one cycle in every 4 cycles (UPD_LOG2 = 2). `word_out` changes only in a cycle in which `word_valid` is high.
- R3: When `spread_en` is 0 at an update, the word delivered with that strobe equals `nominal_word` exactly, with `phase_rising` 0. This holds whether or not a profile was running.
- R4: The code counts in 0.25 % units. It is clamped to 1..10 for center spread (`spread_mode`=0) and to 2..20 for down spread (`spread_mode`=1). The peak deviation is dev = floor(nominal × code × 41943 / 2^24).
- R5: Let P = `period_cycles` / 4, rounded down. Each ramp segment lasts H updates, where H = P/4 for center spread and H = P/2 for down spread, both rounded down, with a minimum of 1. Let u(k) = floor(dev·k/H).
- R6: For center spread, update n of the profile uses m = n mod 4H, s = m/H and j = m mod H. The word is nominal + u(j), nominal + u(H−j), nominal − u(j) and nominal − u(H−j) for s = 0, 1, 2 and 3. The maximum is nominal+dev, the minimum is nominal−dev, and they are symmetric about nominal.
- R7: For down spread, with m = n mod 2H, the word is nominal − u(j) for s = 0 and nominal − u(H−j) for s = 1. It never exceeds nominal and reaches nominal−dev.
- R8: `phase_rising` is 1 when the word belongs to a rising segment: center s = 0 or 3, down s = 1. It is 0 otherwise.
- R9: When the enable is seen high at an update while no profile is running, that update delivers the nominal word as profile sample n = 0, and the profile continues from there.
- R10: A change of code, shape, period or nominal made during a period leaves the rest of that period unchanged. The change applies from the next period start, provided it was settled at least 34 cycles before that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nominal_word | input | WORD_W | Unmodulated control word |
| spread_mode | input | 1 | 0 center spread, 1 down spread |
| spread_code | input | MAG_W | Magnitude in 0.25 % units |
| period_cycles | input | PER_W | Reference cycles per modulation period |
| spread_en | input | 1 | 1 modulate, 0 nominal only |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| word_out | output | WORD_W | Registered control word |
| phase_rising | output | 1 | 1 while the frequency is sweeping upward |

## Verification
The hardest case to reach is a change of magnitude that arrives partway through a running period. Only a full period of samples can show whether the new value stayed out until the period boundary. The bench starts a center profile, changes the code a few updates in, and compares two complete periods against the old and then the new deviation. Segment lengths of one update, where each ramp is a single jump to the peak, are driven with very short period counts.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  typedef enum logic {
    MODE_CENTER = 1'b0,
    MODE_DOWN   = 1'b1
  } spread_mode_e;

  // Percent scaling: 0.25 % = 1/400, applied as a reciprocal multiply.
  localparam int unsigned PCT_SHIFT = 24;
  localparam int unsigned PCT_RECIP = ((1 << PCT_SHIFT) + 200) / 400;

  // Legal magnitude code windows (0.25 % units).
  localparam int unsigned CTR_CODE_MIN = 1;
  localparam int unsigned CTR_CODE_MAX = 10;
  localparam int unsigned DN_CODE_MIN  = 2;
  localparam int unsigned DN_CODE_MAX  = 20;

  function automatic int unsigned clamp_code(input int unsigned code, input logic is_down);
    int unsigned lo;
    int unsigned hi;
    lo = is_down ? DN_CODE_MIN : CTR_CODE_MIN;
    hi = is_down ? DN_CODE_MAX : CTR_CODE_MAX;
    if (code < lo) return lo;
    if (code > hi) return hi;
    return code;
  endfunction

endpackage

// File: rtl/sscg_update_tick.sv
module sscg_update_tick #(
  parameter int unsigned UPD_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (UPD_LOG2 == 0) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [UPD_LOG2-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = &cnt_q;

      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/sscg_cfg_calc.sv
module sscg_cfg_calc #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned MAG_W    = 5,
  parameter int unsigned PER_W    = 16,
  parameter int unsigned UPD_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] nominal_i,
  input  logic              mode_down_i,
  input  logic [MAG_W-1:0]  code_i,
  input  logic [PER_W-1:0]  period_i,
  output logic              cfg_ok_o,
  output logic [WORD_W-1:0] nom_o,
  output logic              down_o,
  output logic [WORD_W-1:0] dev_o,
  output logic [WORD_W-1:0] quo_o,
  output logic [PER_W-1:0]  rem_o,
  output logic [PER_W-1:0]  seg_o
);
  import sscg_pkg::*;

  localparam int unsigned PROD_W = WORD_W + MAG_W + PCT_SHIFT;
  localparam int unsigned KEY_W  = WORD_W + 1 + MAG_W + PER_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W) + 1;
  localparam int unsigned CHK_W  = WORD_W + PER_W + 1;

  logic [MAG_W-1:0]  code_c;
  logic [PER_W-1:0]  per_upd;
  logic [PER_W-1:0]  seg_c;
  logic [PROD_W-1:0] prod;
  logic [WORD_W-1:0] dev_c;
  logic [KEY_W-1:0]  key_c;

  always_comb begin
    code_c  = MAG_W'(clamp_code(32'(code_i), mode_down_i));
    per_upd = period_i >> UPD_LOG2;
    seg_c   = mode_down_i ? (per_upd >> 1) : (per_upd >> 2);
    if (seg_c == '0) seg_c = PER_W'(1);
    prod    = PROD_W'(nominal_i) * PROD_W'(code_c) * PROD_W'(PCT_RECIP);
    dev_c   = WORD_W'(prod >> PCT_SHIFT);
    key_c   = {nominal_i, mode_down_i, code_c, seg_c};
  end

  // Settings latched for the divider and handed to the stepper
  logic [KEY_W-1:0]  key_q;
  logic [WORD_W-1:0] dev_q;
  logic [PER_W-1:0]  seg_q;
  logic [WORD_W-1:0] dvd_q;
  logic [PER_W-1:0]  rem_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              done_q;

  // One restoring-division step per cycle: dev / seg
  logic [PER_W:0] rem_sh;
  logic           ge;

  always_comb begin
    rem_sh = {rem_q, dvd_q[WORD_W-1]};
    ge     = (rem_sh >= {1'b0, seg_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      dev_q  <= '0;
      seg_q  <= PER_W'(1);
      dvd_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (key_c != key_q) begin
      key_q  <= key_c;
      dev_q  <= dev_c;
      seg_q  <= seg_c;
      dvd_q  <= dev_c;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      dvd_q <= {dvd_q[WORD_W-2:0], ge};
      rem_q <= PER_W'(ge ? (rem_sh - {1'b0, seg_q}) : rem_sh);
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(WORD_W - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign cfg_ok_o = done_q && (key_c == key_q);
  assign nom_o    = key_q[KEY_W-1 -: WORD_W];
  assign down_o   = key_q[MAG_W + PER_W];
  assign dev_o    = dev_q;
  assign quo_o    = dvd_q;
  assign rem_o    = rem_q;
  assign seg_o    = seg_q;

  // Quotient and remainder rebuild the deviation exactly (R6 exact ramp ends)
  assert_div_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((CHK_W'(dvd_q) * CHK_W'(seg_q) + CHK_W'(rem_q)) == CHK_W'(dev_q))
               && (rem_q < seg_q));

endmodule

// File: rtl/sscg_tri_stepper.sv
module sscg_tri_stepper #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              spread_en_i,
  input  logic [WORD_W-1:0] nominal_in_i,
  input  logic              cfg_ok_i,
  input  logic [WORD_W-1:0] cfg_nom_i,
  input  logic              cfg_down_i,
  input  logic [WORD_W-1:0] cfg_dev_i,
  input  logic [WORD_W-1:0] cfg_quo_i,
  input  logic [PER_W-1:0]  cfg_rem_i,
  input  logic [PER_W-1:0]  cfg_seg_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              rising_o
);

  // Active setting, swapped only at a period start
  logic [WORD_W-1:0] a_nom, a_dev, a_quo;
  logic [PER_W-1:0]  a_rem, a_seg;
  logic              a_down;
  // Ramp position: k in 0..seg, u = floor(dev*k/seg), err = (dev*k) mod seg
  logic              run_q, up_q, neg_q;
  logic [PER_W-1:0]  k_q, err_q;
  logic [WORD_W-1:0] u_q;

  logic              at_start, load;
  logic [WORD_W-1:0] nom_use, quo_use, u_use;
  logic [PER_W-1:0]  rem_use, seg_use, k_use, err_use;
  logic              down_use, up_use, neg_use;
  logic [WORD_W-1:0] word_nx;
  logic              rise_nx;
  logic [PER_W:0]    sum;
  logic              carry, borrow;
  logic [WORD_W-1:0] u_adv;
  logic [PER_W-1:0]  k_adv, err_adv;
  logic              up_adv, neg_adv;

  always_comb begin
    at_start = run_q && (k_q == '0) && up_q && (neg_q == a_down);
    load     = spread_en_i && cfg_ok_i && (!run_q || at_start);

    nom_use  = load ? cfg_nom_i  : a_nom;
    quo_use  = load ? cfg_quo_i  : a_quo;
    rem_use  = load ? cfg_rem_i  : a_rem;
    seg_use  = load ? cfg_seg_i  : a_seg;
    down_use = load ? cfg_down_i : a_down;
    k_use    = load ? '0         : k_q;
    err_use  = load ? '0         : err_q;
    u_use    = load ? '0         : u_q;
    up_use   = load ? 1'b1       : up_q;
    neg_use  = load ? cfg_down_i : neg_q;

    word_nx  = neg_use ? (nom_use - u_use) : (nom_use + u_use);
    rise_nx  = up_use ^ neg_use;

    sum    = {1'b0, err_use} + {1'b0, rem_use};
    carry  = (sum >= {1'b0, seg_use});
    borrow = (err_use < rem_use);
    if (up_use) begin
      err_adv = PER_W'(carry ? (sum - {1'b0, seg_use}) : sum);
      u_adv   = u_use + quo_use + WORD_W'(carry);
      k_adv   = k_use + 1'b1;
      up_adv  = (k_adv != seg_use);
      neg_adv = neg_use;
    end else begin
      err_adv = PER_W'(borrow ? ({1'b0, err_use} + {1'b0, seg_use} - {1'b0, rem_use})
                              : ({1'b0, err_use} - {1'b0, rem_use}));
      u_adv   = u_use - quo_use - WORD_W'(borrow);
      k_adv   = k_use - 1'b1;
      up_adv  = (k_adv == '0);
      neg_adv = (k_adv == '0) ? (down_use ? 1'b1 : ~neg_use) : neg_use;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_nom <= '0; a_dev <= '0; a_quo <= '0;
      a_rem <= '0; a_seg <= '0; a_down <= 1'b0;
      run_q <= 1'b0; up_q <= 1'b1; neg_q <= 1'b0;
      k_q <= '0; err_q <= '0; u_q <= '0;
      word_o <= '0; rising_o <= 1'b0; word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= tick_i;
      if (tick_i) begin
        if (!spread_en_i) begin
          run_q    <= 1'b0;
          word_o   <= nominal_in_i;
          rising_o <= 1'b0;
        end else if (load || run_q) begin
          if (load) begin
            a_nom  <= cfg_nom_i;
            a_dev  <= cfg_dev_i;
            a_quo  <= cfg_quo_i;
            a_rem  <= cfg_rem_i;
            a_seg  <= cfg_seg_i;
            a_down <= cfg_down_i;
          end
          run_q    <= 1'b1;
          k_q      <= k_adv;
          err_q    <= err_adv;
          u_q      <= u_adv;
          up_q     <= up_adv;
          neg_q    <= neg_adv;
          word_o   <= word_nx;
          rising_o <= rise_nx;
        end else begin
          word_o   <= nominal_in_i;
          rising_o <= 1'b0;
        end
      end
    end
  end

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  assert_off_nominal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !spread_en_i) |=> (word_o == $past(nominal_in_i)) && !rising_o);

  assert_peak_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (u_q <= a_dev) && (err_q < a_seg) && (k_q <= a_seg));

  assert_down_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && a_down) |-> neg_q);

  assert_restart_nominal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && spread_en_i && cfg_ok_i && !run_q)
      |=> (word_o == $past(cfg_nom_i)) && (rising_o == !$past(cfg_down_i)));

endmodule

// File: rtl/sscg_profile_gen.sv
module sscg_profile_gen #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned MAG_W    = 5,
  parameter int unsigned PER_W    = 16,
  parameter int unsigned UPD_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] nominal_word,
  input  logic              spread_mode,
  input  logic [MAG_W-1:0]  spread_code,
  input  logic [PER_W-1:0]  period_cycles,
  input  logic              spread_en,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  output logic              phase_rising
);
  import sscg_pkg::*;

  spread_mode_e      mode_e;
  logic              is_down;
  logic              tick;
  logic              cfg_ok;
  logic [WORD_W-1:0] cfg_nom, cfg_dev, cfg_quo;
  logic              cfg_down;
  logic [PER_W-1:0]  cfg_rem, cfg_seg;

  assign mode_e  = spread_mode_e'(spread_mode);
  assign is_down = (mode_e == MODE_DOWN);

  sscg_update_tick #(.UPD_LOG2(UPD_LOG2)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  sscg_cfg_calc #(
    .WORD_W(WORD_W), .MAG_W(MAG_W), .PER_W(PER_W), .UPD_LOG2(UPD_LOG2)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .nominal_i   (nominal_word),
    .mode_down_i (is_down),
    .code_i      (spread_code),
    .period_i    (period_cycles),
    .cfg_ok_o    (cfg_ok),
    .nom_o       (cfg_nom),
    .down_o      (cfg_down),
    .dev_o       (cfg_dev),
    .quo_o       (cfg_quo),
    .rem_o       (cfg_rem),
    .seg_o       (cfg_seg)
  );

  sscg_tri_stepper #(.WORD_W(WORD_W), .PER_W(PER_W)) u_step (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .spread_en_i  (spread_en),
    .nominal_in_i (nominal_word),
    .cfg_ok_i     (cfg_ok),
    .cfg_nom_i    (cfg_nom),
    .cfg_down_i   (cfg_down),
    .cfg_dev_i    (cfg_dev),
    .cfg_quo_i    (cfg_quo),
    .cfg_rem_i    (cfg_rem),
    .cfg_seg_i    (cfg_seg),
    .word_valid_o (word_valid),
    .word_o       (word_out),
    .rising_o     (phase_rising)
  );

endmodule

// File: tb/sscg_profile_gen_tb.sv
module sscg_profile_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] nominal = 32'd1000000;
  logic        mode = 1'b0;
  logic [4:0]  code = 5'd4;
  logic [15:0] period = 16'd1667;
  logic        en = 1'b0;
  logic        valid;
  logic [31:0] word;
  logic        rising;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk = ~clk;

  sscg_profile_gen u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .nominal_word  (nominal),
    .spread_mode   (mode),
    .spread_code   (code),
    .period_cycles (period),
    .spread_en     (en),
    .word_valid    (valid),
    .word_out      (word),
    .phase_rising  (rising)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------- reference model from the requirements ----------
  function automatic longint f_dev(input longint nom, input int c, input bit md);
    int cc;
    cc = c;
    if (md) begin if (cc < 2) cc = 2; if (cc > 20) cc = 20; end
    else    begin if (cc < 1) cc = 1; if (cc > 10) cc = 10; end
    return (nom * cc * 41943) >>> 24;
  endfunction

  function automatic int f_h(input int per, input bit md);
    int p, h;
    p = per / 4;
    h = md ? p / 2 : p / 4;
    if (h == 0) h = 1;
    return h;
  endfunction

  function automatic longint f_off(input longint dev, input int h, input bit md, input int n);
    int m, s, j;
    m = md ? n % (2*h) : n % (4*h);
    s = m / h;
    j = m % h;
    if (md) return (s == 0) ? -(dev*j/h) : -(dev*(h-j)/h);
    case (s)
      0:       return  (dev*j/h);
      1:       return  (dev*(h-j)/h);
      2:       return -(dev*j/h);
      default: return -(dev*(h-j)/h);
    endcase
  endfunction

  function automatic bit f_rise(input int h, input bit md, input int n);
    int s;
    s = md ? (n % (2*h)) / h : (n % (4*h)) / h;
    return md ? (s == 1) : (s == 0 || s == 3);
  endfunction

  // ---------- background strobe checker (R2) ----------
  int          gap = 0;
  bit          seen = 0;
  logic [31:0] prev_w = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0; seen = 0; prev_w = word;
    end else begin
      gap++;
      if (valid) begin
        if (seen) check(gap == 4, "R2 strobe spacing", gap, 4);
        seen = 1; gap = 0;
      end else begin
        check(word == prev_w, "R2 word held between strobes", word, prev_w);
      end
      prev_w = word;
    end
  end

  task automatic get_sample(output logic [31:0] w, output logic ph);
    do @(negedge clk); while (!valid);
    w  = word;
    ph = rising;
  endtask

  task automatic run_profile(input logic [31:0] nom, input bit md, input int c, input int per,
                             input int nsamp, input string tag,
                             output longint mx, output longint mn);
    longint dev, ew;
    int h;
    logic [31:0] w;
    logic ph;
    en = 1'b0; nominal = nom; mode = md; code = 5'(c); period = 16'(per);
    repeat (60) @(negedge clk);
    en = 1'b1;
    dev = f_dev(nom, c, md);
    h   = f_h(per, md);
    mx = 0; mn = 64'h7fffffffffffffff;
    for (int n = 0; n < nsamp; n++) begin
      get_sample(w, ph);
      ew = longint'(nom) + f_off(dev, h, md, n);
      check(longint'(w) == ew, tag, w, ew);
      check(ph == f_rise(h, md, n), {tag, " phase R8"}, ph, f_rise(h, md, n));
      if (longint'(w) > mx) mx = w;
      if (longint'(w) < mn) mn = w;
    end
  endtask

  // ---------- scenarios ----------
  task automatic t_reset;
    check(valid == 1'b0, "R1 valid after reset", valid, 0);
    check(word == 32'd0, "R1 word after reset", word, 0);
    check(rising == 1'b0, "R1 phase after reset", rising, 0);
  endtask

  task automatic t_spread_off;
    logic [31:0] w; logic ph;
    en = 1'b0; nominal = 32'd123456;
    get_sample(w, ph); get_sample(w, ph);
    check(w == 32'd123456, "R3 nominal while disabled", w, 123456);
    check(ph == 1'b0, "R3 phase while disabled", ph, 0);
    nominal = 32'hCAFE0000;
    get_sample(w, ph); get_sample(w, ph);
    check(w == 32'hCAFE0000, "R3 nominal follows input", w, 32'hCAFE0000);
  endtask

  task automatic t_center;
    longint mx, mn, dev;
    run_profile(32'd1000000, 1'b0, 4, 1667, 2*4*104, "R6 center profile", mx, mn);
    dev = f_dev(1000000, 4, 1'b0);
    check(f_h(1667, 1'b0) == 104, "R5 center segment length", f_h(1667, 1'b0), 104);
    check(mx == 1000000 + dev, "R6 center maximum", mx, 1000000 + dev);
    check(mn == 1000000 - dev, "R6 center minimum", mn, 1000000 - dev);
    check(mx + mn == 2000000, "R6 symmetry about nominal", mx + mn, 2000000);
    en = 1'b0;
  endtask

  task automatic t_down;
    longint mx, mn, dev;
    run_profile(32'd1000000, 1'b1, 8, 1667, 2*2*208, "R7 down profile", mx, mn);
    dev = f_dev(1000000, 8, 1'b1);
    check(mx == 1000000, "R7 down never above nominal", mx, 1000000);
    check(mn == 1000000 - dev, "R7 down minimum", mn, 1000000 - dev);
    en = 1'b0;
  endtask

  task automatic t_clamp;
    longint mx, mn;
    run_profile(32'd50000000, 1'b0, 15, 64, 32, "R4 center code above range", mx, mn);
    check(mx - 50000000 == f_dev(50000000, 10, 1'b0), "R4 center clamp to 10", mx - 50000000, f_dev(50000000, 10, 1'b0));
    run_profile(32'd50000000, 1'b0, 0, 64, 16, "R4 center code zero", mx, mn);
    check(mx - 50000000 == f_dev(50000000, 1, 1'b0), "R4 center clamp to 1", mx - 50000000, f_dev(50000000, 1, 1'b0));
    run_profile(32'd50000000, 1'b1, 1, 64, 32, "R4 down code below range", mx, mn);
    check(50000000 - mn == f_dev(50000000, 2, 1'b1), "R4 down clamp to 2", 50000000 - mn, f_dev(50000000, 2, 1'b1));
    run_profile(32'd50000000, 1'b1, 31, 64, 32, "R4 down code above range", mx, mn);
    check(50000000 - mn == f_dev(50000000, 20, 1'b1), "R4 down clamp to 20", 50000000 - mn, f_dev(50000000, 20, 1'b1));
    en = 1'b0;
  endtask

  task automatic t_tiny;
    longint mx, mn;
    run_profile(32'd8000000, 1'b0, 10, 16, 12, "R5 center one-update segments", mx, mn);
    run_profile(32'd8000000, 1'b1, 20, 8, 8, "R5 down one-update segments", mx, mn);
    run_profile(32'd8000000, 1'b0, 6, 0, 8, "R5 zero period floors to one", mx, mn);
    en = 1'b0;
  endtask

  task automatic t_disable_restart;
    longint mx, mn, dev;
    logic [31:0] w; logic ph;
    run_profile(32'd2000000, 1'b0, 8, 256, 11, "R9 profile before disable", mx, mn);
    en = 1'b0;
    get_sample(w, ph);
    check(w == 32'd2000000, "R3 disable mid-period gives nominal", w, 2000000);
    check(ph == 1'b0, "R3 disable mid-period phase", ph, 0);
    nominal = 32'd3000000;
    repeat (60) @(negedge clk);
    en = 1'b1;
    dev = f_dev(3000000, 8, 1'b0);
    for (int n = 0; n < 20; n++) begin
      get_sample(w, ph);
      check(longint'(w) == 3000000 + f_off(dev, 16, 1'b0, n), "R9 restart at nominal point", w, 3000000 + f_off(dev, 16, 1'b0, n));
      check(ph == f_rise(16, 1'b0, n), "R9 restart phase", ph, f_rise(16, 1'b0, n));
    end
    en = 1'b0;
  endtask

  task automatic t_cfg_change;
    logic [31:0] w; logic ph;
    longint ew;
    en = 1'b0; nominal = 32'd4000000; mode = 1'b0; code = 5'd4; period = 16'd256;
    repeat (60) @(negedge clk);
    en = 1'b1;
    for (int n = 0; n < 128; n++) begin
      get_sample(w, ph);
      ew = 4000000 + f_off(f_dev(4000000, (n < 64) ? 4 : 8, 1'b0), 16, 1'b0, n);
      check(longint'(w) == ew, "R10 change waits for period start", w, ew);
      if (n == 8) code = 5'd8;
    end
    en = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_spread_off();
    t_center();
    t_down();
    t_clamp();
    t_tiny();
    t_disable_restart();
    t_cfg_change();
    repeat (8) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule